// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block translates 32-bit virtual addresses to 30-bit physical addresses for 4 KB pages. It holds 32 translations, and any slot can hold any virtual page. The upper 20 bits of the address are the virtual page number. A lookup compares that number against every slot in parallel. A match with the right permission returns the 18-bit physical page number joined with the untouched 12-bit offset. The answer is registered and appears one cycle after the request.

Each slot has a valid bit, a read-permission bit and a write-permission bit. A lookup that matches but lacks the permission its access needs raises a protection fault instead of a translation. A lookup with no match raises a miss, so that an external walker can fetch the page-table entry and install it through the separate fill port. A fill first reuses a slot that already holds the same page, then takes the lowest-numbered empty slot, and otherwise evicts the least recently used slot. A flush input empties the whole buffer in one cycle.

Top module: `page_xlate_buf`

## Requirements
- R1: After reset `rsp_valid_o`, `rsp_hit_o`, `rsp_miss_o`, `rsp_fault_o` and `rsp_paddr_o` are zero, and every slot is empty, so the first lookup of any page misses.
- R2: A request sampled at a rising edge with `req_valid_i` high answers on the outputs after that edge, with `rsp_valid_o` high and exactly one of hit, miss or fault set. A cycle without a request gives all four flags low and `rsp_paddr_o` zero.
- R3: A lookup hits when a valid slot holds its page number and the slot grants the access (read permission for `req_write_i`=0, write permission for `req_write_i`=1). `rsp_paddr_o` is then {stored 18-bit page, vaddr[11:0]}.
- R4: A lookup whose page number matches no valid slot raises `rsp_miss_o`, and `rsp_paddr_o` is zero.
- R5: A write lookup that matches a slot whose write permission is clear raises `rsp_fault_o`, with `rsp_hit_o` low and `rsp_paddr_o` zero.
- R6: A read lookup that matches a slot whose read permission is clear raises `rsp_fault_o`, with `rsp_hit_o` low and `rsp_paddr_o` zero.
- R7: A fill whose page number already sits in a valid slot overwrites that slot's page and permissions. No second copy is made, and no other slot is evicted.
- R8: A fill of a new page, while some slot is empty, writes an empty slot and evicts nothing.
- R9: A fill of a new page into a full buffer replaces the least recently used slot. A fill, or a lookup that hits, counts as a use. A fill and a lookup in the same cycle count only the fill as a use.
- R10: `flush_i` empties every slot at the next edge. A fill in the same cycle as a flush is dropped.
- R11: A lookup in the same cycle as a fill or a flush answers from the contents held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty every slot |
| req_valid_i | input | 1 | Lookup request |
| req_write_i | input | 1 | Lookup is a write (1) or a read (0) |
| req_vaddr_i | input | 32 | Virtual address to translate |
| fill_valid_i | input | 1 | Install a translation |
| fill_vpn_i | input | 20 | Virtual page number to install |
| fill_ppn_i | input | 18 | Physical page number to install |
| fill_rd_i | input | 1 | Read permission of the new translation |
| fill_wr_i | input | 1 | Write permission of the new translation |
| rsp_valid_o | output | 1 | Answer to the previous cycle's request |
| rsp_hit_o | output | 1 | Translation found and permitted |
| rsp_miss_o | output | 1 | No valid slot holds the page |
| rsp_fault_o | output | 1 | Page present but access not permitted |
| rsp_paddr_o | output | 30 | Physical address on a hit, else zero |

## Verification
A wrong valid bit or tag shows at the ports on the very next lookup of that page, as a miss where a hit was due or the reverse. A wrong permission bit shows as a fault swapped with a hit. Corrupt recency order stays hidden until the buffer is full and a fill evicts a slot. It then shows as a miss on a page that should have survived, so the bench fills all 32 slots and probes survivors right after each eviction. A duplicate made by a refill of a resident page also surfaces only through eviction, so the bench refills a resident page while the buffer is full and then checks that every page still hits.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_HIT   = 2'd1,
    RSP_MISS  = 2'd2,
    RSP_FAULT = 2'd3
  } rsp_kind_e;
endpackage

// File: rtl/pxb_entries.sv
module pxb_entries #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 18,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [VPN_W-1:0]   wr_vpn_i,
  input  logic [PPN_W-1:0]   wr_ppn_i,
  input  logic               wr_rd_i,
  input  logic               wr_wr_i,
  input  logic [VPN_W-1:0]   lk_vpn_i,
  output logic [ENTRIES-1:0] lk_match_o,
  output logic [PPN_W-1:0]   lk_ppn_o,
  output logic               lk_rd_o,
  output logic               lk_wr_o,
  output logic [ENTRIES-1:0] fl_match_o,
  output logic [ENTRIES-1:0] valid_o
);
  logic [ENTRIES-1:0] vld_q, rd_q, wr_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (flush_i) vld_q <= '0;
    else if (wr_en_i) vld_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !flush_i) begin
      vpn_q[wr_idx_i] <= wr_vpn_i;
      ppn_q[wr_idx_i] <= wr_ppn_i;
      rd_q[wr_idx_i]  <= wr_rd_i;
      wr_q[wr_idx_i]  <= wr_wr_i;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match_o[g] = vld_q[g] && (vpn_q[g] == lk_vpn_i);
    assign fl_match_o[g] = vld_q[g] && (vpn_q[g] == wr_vpn_i);
  end

  // match vector is one-hot at most, so OR-reduce the selected slot
  always_comb begin
    lk_ppn_o = '0;
    lk_rd_o  = 1'b0;
    lk_wr_o  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match_o[i]) begin
        lk_ppn_o = lk_ppn_o | ppn_q[i];
        lk_rd_o  = lk_rd_o | rd_q[i];
        lk_wr_o  = lk_wr_o | wr_q[i];
      end
    end
  end

  assign valid_o = vld_q;
endmodule

// File: rtl/pxb_age.sv
module pxb_age #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] oldest_o
);
  // ages form a permutation of 0..ENTRIES-1; 0 = most recent
  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] ref_age;

  assign ref_age = age_q[touch_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx_i) age_q[i] <= '0;
        else if (age_q[i] < ref_age)  age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_o = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (age_q[i] == IDX_W'(ENTRIES - 1)) oldest_o = IDX_W'(i);
  end
endmodule

// File: rtl/pxb_slot_pick.sv
module pxb_slot_pick #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] dup_match_i,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [IDX_W-1:0]   oldest_i,
  output logic [IDX_W-1:0]   slot_o
);
  logic [IDX_W-1:0] dup_idx, free_idx;

  always_comb begin
    dup_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (dup_match_i[i]) dup_idx = IDX_W'(i);
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_i[i]) free_idx = IDX_W'(i);
  end

  always_comb begin
    if (|dup_match_i)   slot_o = dup_idx;
    else if (~&valid_i) slot_o = free_idx;
    else                slot_o = oldest_i;
  end
endmodule

// File: rtl/page_xlate_buf.sv
module page_xlate_buf #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 18,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_rd_i,
  input  logic             fill_wr_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic             rsp_miss_o,
  output logic             rsp_fault_o,
  output logic [PA_W-1:0]  rsp_paddr_o
);
  import pxb_pkg::*;

  logic [ENTRIES-1:0] lk_match, fl_match, valid_vec;
  logic [PPN_W-1:0]   lk_ppn;
  logic               lk_rd, lk_wr, lk_any, lk_ok;
  logic               fill_en, touch;
  logic [IDX_W-1:0]   fill_idx, lk_idx, touch_idx, oldest;
  rsp_kind_e          kind_q;
  logic [PA_W-1:0]    paddr_q;

  assign fill_en = fill_valid_i && !flush_i;

  pxb_entries #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_entries (
    .clk_i, .rst_ni, .flush_i,
    .wr_en_i    (fill_en),
    .wr_idx_i   (fill_idx),
    .wr_vpn_i   (fill_vpn_i),
    .wr_ppn_i   (fill_ppn_i),
    .wr_rd_i    (fill_rd_i),
    .wr_wr_i    (fill_wr_i),
    .lk_vpn_i   (req_vaddr_i[VA_W-1:OFF_W]),
    .lk_match_o (lk_match),
    .lk_ppn_o   (lk_ppn),
    .lk_rd_o    (lk_rd),
    .lk_wr_o    (lk_wr),
    .fl_match_o (fl_match),
    .valid_o    (valid_vec)
  );

  pxb_slot_pick #(.ENTRIES(ENTRIES)) u_pick (
    .dup_match_i (fl_match),
    .valid_i     (valid_vec),
    .oldest_i    (oldest),
    .slot_o      (fill_idx)
  );

  assign lk_any = |lk_match;
  assign lk_ok  = lk_any && (req_write_i ? lk_wr : lk_rd);

  always_comb begin
    lk_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lk_match[i]) lk_idx = IDX_W'(i);
  end

  // a fill in the same cycle owns the recency update
  assign touch     = fill_en || (req_valid_i && lk_ok);
  assign touch_idx = fill_en ? fill_idx : lk_idx;

  pxb_age #(.ENTRIES(ENTRIES)) u_age (
    .clk_i, .rst_ni,
    .touch_i     (touch),
    .touch_idx_i (touch_idx),
    .oldest_o    (oldest)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= RSP_NONE;
      paddr_q <= '0;
    end else begin
      paddr_q <= '0;
      if (!req_valid_i)  kind_q <= RSP_NONE;
      else if (!lk_any)  kind_q <= RSP_MISS;
      else if (!lk_ok)   kind_q <= RSP_FAULT;
      else begin
        kind_q  <= RSP_HIT;
        paddr_q <= {lk_ppn, req_vaddr_i[OFF_W-1:0]};
      end
    end
  end

  assign rsp_valid_o = (kind_q != RSP_NONE);
  assign rsp_hit_o   = (kind_q == RSP_HIT);
  assign rsp_miss_o  = (kind_q == RSP_MISS);
  assign rsp_fault_o = (kind_q == RSP_FAULT);
  assign rsp_paddr_o = paddr_q;
endmodule

// File: rtl/pxb_checker.sv
module pxb_checker #(
  parameter int ENTRIES = 32,
  parameter int PA_W    = 30,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               flush_i,
  input logic               req_valid_i,
  input logic               rsp_valid_o,
  input logic               rsp_hit_o,
  input logic               rsp_miss_o,
  input logic               rsp_fault_o,
  input logic [PA_W-1:0]    rsp_paddr_o,
  input logic               fill_en,
  input logic [ENTRIES-1:0] fl_match,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [IDX_W-1:0]   fill_idx
);
  assert_rsp_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !rsp_hit_o && !rsp_miss_o && !rsp_fault_o && rsp_paddr_o == '0);

  assert_one_outcome_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $onehot({rsp_hit_o, rsp_miss_o, rsp_fault_o}));

  assert_no_addr_on_reject_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_fault_o || rsp_miss_o) |-> rsp_paddr_o == '0);

  assert_free_slot_first_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en && !(|fl_match) && !(&valid_vec)) |-> !valid_vec[fill_idx]);

  assert_dup_reused_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_en && (|fl_match)) |=> $countones(valid_vec) == $countones($past(valid_vec)));

  assert_fill_installs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en |=> valid_vec[$past(fill_idx)]);

  assert_flush_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> valid_vec == '0);
endmodule

bind page_xlate_buf pxb_checker #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_chk (
  .clk_i, .rst_ni, .flush_i, .req_valid_i,
  .rsp_valid_o, .rsp_hit_o, .rsp_miss_o, .rsp_fault_o, .rsp_paddr_o,
  .fill_en, .fl_match, .valid_vec, .fill_idx
);

// File: tb/page_xlate_buf_tb.sv
module page_xlate_buf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 56;
  localparam logic [1:0] OP_FILL = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_FLUSH = 2'd3;
  localparam logic [1:0] K_HIT = 2'd1, K_MISS = 2'd2, K_FAULT = 2'd3;

  function automatic logic [VW-1:0] mk(logic [1:0] op, logic [19:0] vpn, logic [17:0] ppn,
                                       logic r, logic w, logic [1:0] k, logic [11:0] off);
    return {op, vpn, ppn, r, w, k, off};
  endfunction

  localparam int NV = 17;
  localparam logic [VW-1:0] VEC [NV] = '{
    mk(OP_RD,    20'h12345, 18'h0,     0, 0, K_MISS,  12'h0AB),
    mk(OP_FILL,  20'h12345, 18'h2A5A5, 1, 1, 2'd0,    12'h0),
    mk(OP_RD,    20'h12345, 18'h2A5A5, 0, 0, K_HIT,   12'hABC),
    mk(OP_WR,    20'h12345, 18'h2A5A5, 0, 0, K_HIT,   12'h001),
    mk(OP_FILL,  20'h00F00, 18'h00111, 1, 0, 2'd0,    12'h0),
    mk(OP_WR,    20'h00F00, 18'h0,     0, 0, K_FAULT, 12'h123),
    mk(OP_RD,    20'h00F00, 18'h00111, 0, 0, K_HIT,   12'hFFF),
    mk(OP_FILL,  20'h7FFFF, 18'h3FFFF, 0, 1, 2'd0,    12'h0),
    mk(OP_RD,    20'h7FFFF, 18'h0,     0, 0, K_FAULT, 12'h555),
    mk(OP_WR,    20'h7FFFF, 18'h3FFFF, 0, 0, K_HIT,   12'h800),
    mk(OP_FILL,  20'h12345, 18'h01234, 1, 0, 2'd0,    12'h0),
    mk(OP_RD,    20'h12345, 18'h01234, 0, 0, K_HIT,   12'h010),
    mk(OP_WR,    20'h12345, 18'h0,     0, 0, K_FAULT, 12'h010),
    mk(OP_RD,    20'h12346, 18'h0,     0, 0, K_MISS,  12'h000),
    mk(OP_FLUSH, 20'h0,     18'h0,     0, 0, 2'd0,    12'h0),
    mk(OP_RD,    20'h7FFFF, 18'h0,     0, 0, K_MISS,  12'h000),
    mk(OP_RD,    20'h00F00, 18'h0,     0, 0, K_MISS,  12'h000)
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic flush = 0, req_valid = 0, req_write = 0;
  logic [31:0] req_vaddr = '0;
  logic fill_valid = 0, fill_rd = 0, fill_wr = 0;
  logic [19:0] fill_vpn = '0;
  logic [17:0] fill_ppn = '0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [29:0] rsp_paddr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xlate_buf u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_vaddr_i(req_vaddr),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
    .fill_rd_i(fill_rd), .fill_wr_i(fill_wr),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_miss_o(rsp_miss),
    .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr)
  );

  task automatic check_rsp(string tag, logic v, logic [1:0] k, logic [29:0] pa);
    logic [33:0] got, exp;
    got = {rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_paddr};
    exp = {v, k == K_HIT, k == K_MISS, k == K_FAULT, pa};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got v/h/m/f=%b pa=%h, expected v/h/m/f=%b pa=%h",
               tag, got[33:30], got[29:0], exp[33:30], exp[29:0]);
    end
  endtask

  task automatic look(string tag, logic wr, logic [19:0] vpn, logic [11:0] off,
                      logic [1:0] k, logic [17:0] ppn);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_vaddr = {vpn, off};
    @(negedge clk);
    req_valid = 0;
    check_rsp(tag, 1'b1, k, (k == K_HIT) ? {ppn, off} : 30'h0);
  endtask

  task automatic fill(logic [19:0] vpn, logic [17:0] ppn, logic r, logic w);
    @(negedge clk);
    fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn; fill_rd = r; fill_wr = w;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no completion, expected end of test");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset and just after
    check_rsp("R1 reset outputs", 1'b0, 2'd0, 30'h0);
    rst_n = 1;
    @(negedge clk);
    check_rsp("R1 idle after reset", 1'b0, 2'd0, 30'h0);

    // table walk: R1 first miss, R3 hits, R4 misses, R5/R6 faults, R7 overwrite, R10 flush
    for (int i = 0; i < NV; i++) begin
      logic [1:0] op, k; logic [19:0] vpn; logic [17:0] ppn; logic r, w; logic [11:0] off;
      {op, vpn, ppn, r, w, k, off} = VEC[i];
      case (op)
        OP_FILL:  fill(vpn, ppn, r, w);
        OP_FLUSH: do_flush();
        default:  look($sformatf("R3/R4/R5/R6/R7/R10 vector %0d", i), op == OP_WR, vpn, off, k, ppn);
      endcase
    end

    // R2: cycle after a response with no request is quiet
    @(negedge clk);
    check_rsp("R2 no request", 1'b0, 2'd0, 30'h0);

    // R8/R9: fill all slots, then evictions follow recency
    for (int i = 0; i < 32; i++) fill(20'h40000 + 20'(i), 18'(i + 1), 1, 1);
    look("R8 all filled slot 0", 0, 20'h40000, 12'h004, K_HIT, 18'd1);
    look("R8 all filled slot 31", 0, 20'h4001F, 12'h004, K_HIT, 18'd32);
    fill(20'h50000, 18'h155, 1, 1);
    look("R9 oldest evicted", 0, 20'h40001, 12'h0, K_MISS, 18'h0);
    look("R9 touched kept", 0, 20'h40000, 12'h0, K_HIT, 18'd1);
    look("R9 new present", 1, 20'h50000, 12'h7FF, K_HIT, 18'h155);
    fill(20'h50001, 18'h156, 1, 1);
    look("R9 next oldest evicted", 0, 20'h40002, 12'h0, K_MISS, 18'h0);

    // R7: refill of a resident page in a full buffer evicts nothing
    fill(20'h40010, 18'h3ABCD, 1, 0);
    look("R7 refill read", 0, 20'h40010, 12'h321, K_HIT, 18'h3ABCD);
    look("R7 refill perms", 1, 20'h40010, 12'h321, K_FAULT, 18'h0);
    look("R7 keep slot 0", 0, 20'h40000, 12'h0, K_HIT, 18'd1);
    for (int i = 3; i < 32; i++)
      if (i != 16) look($sformatf("R7 keep page %0d", i), 0, 20'h40000 + 20'(i), 12'h0, K_HIT, 18'(i + 1));
    look("R7 keep new 0", 0, 20'h50000, 12'h0, K_HIT, 18'h155);
    look("R7 keep new 1", 0, 20'h50001, 12'h0, K_HIT, 18'h156);

    // R10/R11: flush with fill in same cycle, lookup sees old contents
    @(negedge clk);
    flush = 1; fill_valid = 1; fill_vpn = 20'h60000; fill_ppn = 18'h777; fill_rd = 1; fill_wr = 1;
    req_valid = 1; req_write = 0; req_vaddr = {20'h50000, 12'h00C};
    @(negedge clk);
    flush = 0; fill_valid = 0; req_valid = 0;
    check_rsp("R11 lookup during flush", 1'b1, K_HIT, {18'h155, 12'h00C});
    look("R10 flush drops fill", 0, 20'h60000, 12'h0, K_MISS, 18'h0);
    look("R10 flush cleared", 0, 20'h50000, 12'h0, K_MISS, 18'h0);

    // R11: lookup and fill of the same page in one cycle
    @(negedge clk);
    fill_valid = 1; fill_vpn = 20'h0ABCD; fill_ppn = 18'h2222; fill_rd = 1; fill_wr = 1;
    req_valid = 1; req_write = 0; req_vaddr = {20'h0ABCD, 12'h044};
    @(negedge clk);
    fill_valid = 0; req_valid = 0;
    check_rsp("R11 lookup during fill", 1'b1, K_MISS, 30'h0);
    look("R11 fill visible after", 0, 20'h0ABCD, 12'h044, K_HIT, 18'h2222);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule